// File: doc/BRIEF.md
# Two-Road Traffic Light Controller

This block runs the lamps at a crossing of a north-south road and an east-west road. A two-bit phase register steps through four phases. In the first, east-west is green. In the second, east-west is yellow. In the third, north-south is green. In the fourth, north-south is yellow. Whichever road is not green or yellow shows red. Every lamp output is driven low to light its lamp. One clock is one time unit, so there is no prescaler inside the block.

A parameter selects what ends a green phase. In the default internal mode, a small tick counter ends green after a fixed number of clocks and the `timer_i` pin has no effect. In external mode, green holds until `timer_i` is sampled high at a clock edge. In both modes the yellow phase lasts a fixed number of clocks and then hands over to the other road with no input condition. With the defaults (4 green clocks, 1 yellow clock), each road gets 4 clocks of green, 1 of yellow and 5 of red in a 10-clock period.

Top module: `xing_light_ctrl`

## Requirements
- R1: While `rst_i` is high at a clock edge, the block enters the east-west green phase and clears its tick counter. On the next cycle `ew_grn_n_o`=0, `ns_red_n_o`=0, and the other four lamp outputs are 1.
- R2: In every cycle after reset, exactly one of the three lamp outputs of each road is low. A low output means the lamp is lit.
- R3: In every cycle exactly one road shows red, so a green or yellow lamp on one road always comes with red on the other.
- R4: In internal mode (TIMER_MODE=0), the phase sequence counted from the last reset edge repeats every 2*(GREEN_LEN+YELLOW_LEN) clocks. Within one period it runs: east-west green for GREEN_LEN clocks, east-west yellow for YELLOW_LEN clocks, north-south green for GREEN_LEN clocks, then north-south yellow for YELLOW_LEN clocks.
- R5: In internal mode, each run of red on a road that is not cut short by reset lasts GREEN_LEN+YELLOW_LEN clocks (5 with the defaults).
- R6: In internal mode, the value of `timer_i` has no effect on any lamp output.
- R7: A yellow phase lasts exactly YELLOW_LEN clocks with no input condition. When it ends, the other road turns green in the same cycle.
- R8: In external mode (TIMER_MODE=1), a green phase continues while `timer_i` is sampled 0. A 1 sampled during green makes the same road yellow from the next cycle.
- R9: A reset asserted in any phase returns the block to the start of R1's east-west green, with a full-length green following.
- R10: A green lamp always hands over to the yellow lamp of the same road. Green never goes straight to red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one period is one time unit |
| rst_i | input | 1 | Synchronous reset, active high |
| timer_i | input | 1 | Ends green in external mode; ignored in internal mode |
| ns_red_n_o | output | 1 | North-south red lamp, low = lit |
| ns_yel_n_o | output | 1 | North-south yellow lamp, low = lit |
| ns_grn_n_o | output | 1 | North-south green lamp, low = lit |
| ew_red_n_o | output | 1 | East-west red lamp, low = lit |
| ew_yel_n_o | output | 1 | East-west yellow lamp, low = lit |
| ew_grn_n_o | output | 1 | East-west green lamp, low = lit |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a phase while the tick counter holds a value other than zero. Only then does a counter that fails to clear make the next green the wrong length. The stimulus sweeps the reset over every one of the ten positions in the period and checks the full period that follows. A second instance in external mode sees `timer_i` held low for runs of zero to five clocks, so green phases of many lengths appear. The timer input of the internal instance is meanwhile driven with a pseudo-random pattern to show that it is ignored.

// File: rtl/xing_light_pkg.sv
package xing_light_pkg;

   // Phase codes: bit 1 selects the road that may move, bit 0 = yellow.
   typedef enum logic [1:0] {
      PH_EW_GO   = 2'b00,
      PH_EW_WARN = 2'b01,
      PH_NS_GO   = 2'b10,
      PH_NS_WARN = 2'b11
   } phase_e;

   // Lamp set of one road, active high inside the block.
   typedef struct packed {
      logic red;
      logic yel;
      logic grn;
   } lamp_t;

   localparam int unsigned ROAD_CNT = 2;
   localparam int unsigned ROAD_EW  = 0;
   localparam int unsigned ROAD_NS  = 1;

endpackage

// File: rtl/light_phase_seq.sv
module light_phase_seq
   import xing_light_pkg::*;
#(
   parameter int unsigned GREEN_LEN  = 4,
   parameter int unsigned YELLOW_LEN = 1,
   parameter int unsigned TIMER_MODE = 0
) (
   input  logic   clk_i,
   input  logic   rst_i,
   input  logic   timer_i,
   output phase_e phase_o
);

   localparam int unsigned CNT_MAX = (GREEN_LEN > YELLOW_LEN) ? GREEN_LEN : YELLOW_LEN;
   localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
   localparam logic [CNT_W-1:0] GRN_LAST = CNT_W'(GREEN_LEN - 1);
   localparam logic [CNT_W-1:0] YEL_LAST = CNT_W'(YELLOW_LEN - 1);
   localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CNT_MAX - 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] tick_q;
   logic             in_green;
   logic             green_end;
   logic             yel_end;
   logic             step;

   assign in_green = ~phase_q[0];

   generate
      if (TIMER_MODE == 0) begin : g_int_timer
         logic unused_timer;
         assign unused_timer = timer_i;
         assign green_end    = (tick_q == GRN_LAST);
      end else begin : g_ext_timer
         assign green_end = timer_i;
      end
   endgenerate

   assign yel_end = (tick_q == YEL_LAST);
   assign step    = in_green ? green_end : yel_end;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_EW_GO;
         tick_q  <= '0;
      end else if (step) begin
         phase_q <= phase_e'(phase_q + 2'd1);
         tick_q  <= '0;
      end else if (tick_q != CNT_TOP) begin
         tick_q  <= tick_q + 1'b1;
      end
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/light_lamp_dec.sv
module light_lamp_dec
   import xing_light_pkg::*;
(
   input  phase_e                 phase_i,
   output lamp_t [ROAD_CNT-1:0]   road_o
);

   generate
      for (genvar r = 0; r < ROAD_CNT; r++) begin : g_road
         localparam logic OWN_BIT = 1'(r);
         logic owner;
         assign owner          = (phase_i[1] == OWN_BIT);
         assign road_o[r].grn  = owner & ~phase_i[0];
         assign road_o[r].yel  = owner &  phase_i[0];
         assign road_o[r].red  = ~owner;
      end
   endgenerate

endmodule

// File: rtl/light_lamp_drive.sv
module light_lamp_drive
   import xing_light_pkg::*;
#(
   parameter int unsigned ACTIVE_LOW = 1
) (
   input  lamp_t [ROAD_CNT-1:0] on_i,
   output lamp_t [ROAD_CNT-1:0] pin_o
);

   generate
      if (ACTIVE_LOW != 0) begin : g_low
         assign pin_o = ~on_i;
      end else begin : g_high
         assign pin_o = on_i;
      end
   endgenerate

endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
   import xing_light_pkg::*;
#(
   parameter int unsigned GREEN_LEN       = 4,
   parameter int unsigned YELLOW_LEN      = 1,
   parameter int unsigned TIMER_MODE      = 0,
   parameter int unsigned LAMP_ACTIVE_LOW = 1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic timer_i,
   output logic ns_red_n_o,
   output logic ns_yel_n_o,
   output logic ns_grn_n_o,
   output logic ew_red_n_o,
   output logic ew_yel_n_o,
   output logic ew_grn_n_o
);

   generate
      if (GREEN_LEN < 1) begin : g_bad_green
         $error("GREEN_LEN must be at least 1");
      end
      if (YELLOW_LEN < 1) begin : g_bad_yellow
         $error("YELLOW_LEN must be at least 1");
      end
      if (TIMER_MODE > 1) begin : g_bad_mode
         $error("TIMER_MODE must be 0 or 1");
      end
      if (LAMP_ACTIVE_LOW > 1) begin : g_bad_pol
         $error("LAMP_ACTIVE_LOW must be 0 or 1");
      end
   endgenerate

   phase_e                phase;
   lamp_t [ROAD_CNT-1:0]  lamp_on;
   lamp_t [ROAD_CNT-1:0]  lamp_pin;

   light_phase_seq #(
      .GREEN_LEN  (GREEN_LEN),
      .YELLOW_LEN (YELLOW_LEN),
      .TIMER_MODE (TIMER_MODE)
   ) u_seq (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .timer_i (timer_i),
      .phase_o (phase)
   );

   light_lamp_dec u_dec (
      .phase_i (phase),
      .road_o  (lamp_on)
   );

   light_lamp_drive #(
      .ACTIVE_LOW (LAMP_ACTIVE_LOW)
   ) u_drv (
      .on_i  (lamp_on),
      .pin_o (lamp_pin)
   );

   assign ns_red_n_o = lamp_pin[ROAD_NS].red;
   assign ns_yel_n_o = lamp_pin[ROAD_NS].yel;
   assign ns_grn_n_o = lamp_pin[ROAD_NS].grn;
   assign ew_red_n_o = lamp_pin[ROAD_EW].red;
   assign ew_yel_n_o = lamp_pin[ROAD_EW].yel;
   assign ew_grn_n_o = lamp_pin[ROAD_EW].grn;

endmodule

// File: rtl/xing_light_chk.sv
module xing_light_chk #(
   parameter int unsigned GREEN_LEN       = 4,
   parameter int unsigned YELLOW_LEN      = 1,
   parameter int unsigned TIMER_MODE      = 0,
   parameter int unsigned LAMP_ACTIVE_LOW = 1
) (
   input logic clk_i,
   input logic rst_i,
   input logic timer_i,
   input logic ns_red_n_o,
   input logic ns_yel_n_o,
   input logic ns_grn_n_o,
   input logic ew_red_n_o,
   input logic ew_yel_n_o,
   input logic ew_grn_n_o
);

   localparam int unsigned RUN_MAX = (GREEN_LEN > YELLOW_LEN) ? GREEN_LEN : YELLOW_LEN;
   localparam int unsigned RUN_W   = $clog2(RUN_MAX + 2) + 1;
   localparam logic [RUN_W-1:0] G_RUN   = RUN_W'(GREEN_LEN);
   localparam logic [RUN_W-1:0] Y_RUN   = RUN_W'(YELLOW_LEN);
   localparam logic [RUN_W-1:0] RUN_TOP = {RUN_W{1'b1}};

   // Lit lamps per road as {red, yel, grn}, active high.
   logic [2:0] ew_on, ns_on;
   assign ew_on = (LAMP_ACTIVE_LOW != 0) ? ~{ew_red_n_o, ew_yel_n_o, ew_grn_n_o}
                                         :  {ew_red_n_o, ew_yel_n_o, ew_grn_n_o};
   assign ns_on = (LAMP_ACTIVE_LOW != 0) ? ~{ns_red_n_o, ns_yel_n_o, ns_grn_n_o}
                                         :  {ns_red_n_o, ns_yel_n_o, ns_grn_n_o};

   // Lit-cycle run counters, one per green and yellow lamp.
   logic [RUN_W-1:0] ew_g_run, ns_g_run, ew_y_run, ns_y_run;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ew_g_run <= '0;
         ns_g_run <= '0;
         ew_y_run <= '0;
         ns_y_run <= '0;
      end else begin
         ew_g_run <= ew_on[0] ? ((ew_g_run == RUN_TOP) ? ew_g_run : ew_g_run + 1'b1) : '0;
         ns_g_run <= ns_on[0] ? ((ns_g_run == RUN_TOP) ? ns_g_run : ns_g_run + 1'b1) : '0;
         ew_y_run <= ew_on[1] ? ((ew_y_run == RUN_TOP) ? ew_y_run : ew_y_run + 1'b1) : '0;
         ns_y_run <= ns_on[1] ? ((ns_y_run == RUN_TOP) ? ns_y_run : ns_y_run + 1'b1) : '0;
      end
   end

   assert_reset_ew_green_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (ew_on == 3'b001) && (ns_on == 3'b100));

   assert_one_lamp_per_road_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      ($countones(ew_on) == 1) && ($countones(ns_on) == 1));

   assert_one_red_road_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      ew_on[2] != ns_on[2]);

   assert_ew_green_to_yellow_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(ew_on[0]) && !$past(rst_i) |-> ew_on[1]);

   assert_ns_green_to_yellow_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(ns_on[0]) && !$past(rst_i) |-> ns_on[1]);

   assert_ew_yellow_bound_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      ew_on[1] |-> ew_y_run < Y_RUN);

   assert_ns_yellow_bound_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      ns_on[1] |-> ns_y_run < Y_RUN);

   assert_ew_yellow_handover_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(ew_on[1]) && !$past(rst_i) |-> ns_on[0] && (ew_y_run == Y_RUN));

   assert_ns_yellow_handover_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(ns_on[1]) && !$past(rst_i) |-> ew_on[0] && (ns_y_run == Y_RUN));

   generate
      if (TIMER_MODE == 0) begin : g_int_checks
         assert_ew_green_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            ew_on[0] |-> ew_g_run < G_RUN);
         assert_ns_green_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            ns_on[0] |-> ns_g_run < G_RUN);
         assert_ew_green_full_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(ew_on[0]) && !$past(rst_i) |-> ew_g_run == G_RUN);
         assert_ns_green_full_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(ns_on[0]) && !$past(rst_i) |-> ns_g_run == G_RUN);
      end else begin : g_ext_checks
         assert_green_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            (ew_on[0] || ns_on[0]) && !timer_i |=> (ew_on[0] || ns_on[0]));
         assert_ew_green_release_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            ew_on[0] && timer_i |=> ew_on[1]);
         assert_ns_green_release_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            ns_on[0] && timer_i |=> ns_on[1]);
      end
   endgenerate

endmodule

bind xing_light_ctrl xing_light_chk #(
   .GREEN_LEN       (GREEN_LEN),
   .YELLOW_LEN      (YELLOW_LEN),
   .TIMER_MODE      (TIMER_MODE),
   .LAMP_ACTIVE_LOW (LAMP_ACTIVE_LOW)
) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .timer_i    (timer_i),
   .ns_red_n_o (ns_red_n_o),
   .ns_yel_n_o (ns_yel_n_o),
   .ns_grn_n_o (ns_grn_n_o),
   .ew_red_n_o (ew_red_n_o),
   .ew_yel_n_o (ew_yel_n_o),
   .ew_grn_n_o (ew_grn_n_o)
);

// File: tb/test_xing_light_ctrl.sv
module test_xing_light_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int G_LEN      = 4;
   localparam int Y_LEN      = 1;
   localparam int PER        = 2 * (G_LEN + Y_LEN);

   logic clk   = 1'b0;
   logic rst   = 1'b1;
   logic tmr   = 1'b0;
   logic tmr_x = 1'b0;

   // Lamp vectors: {ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn}, active low.
   logic [5:0] la, lx;

   always #(CLK_PERIOD / 2) clk = ~clk;

   xing_light_ctrl #(.GREEN_LEN(G_LEN), .YELLOW_LEN(Y_LEN), .TIMER_MODE(0)) i_xing_light_ctrl (
      .clk_i(clk), .rst_i(rst), .timer_i(tmr),
      .ns_red_n_o(la[5]), .ns_yel_n_o(la[4]), .ns_grn_n_o(la[3]),
      .ew_red_n_o(la[2]), .ew_yel_n_o(la[1]), .ew_grn_n_o(la[0]));

   xing_light_ctrl #(.GREEN_LEN(G_LEN), .YELLOW_LEN(Y_LEN), .TIMER_MODE(1)) i_xing_light_ctrl_ext (
      .clk_i(clk), .rst_i(rst), .timer_i(tmr_x),
      .ns_red_n_o(lx[5]), .ns_yel_n_o(lx[4]), .ns_grn_n_o(lx[3]),
      .ew_red_n_o(lx[2]), .ew_yel_n_o(lx[1]), .ew_grn_n_o(lx[0]));

   int errors = 0;
   int checks = 0;
   int n      = 0;   // edges since the last reset edge (internal model)
   int xp     = 0;   // phase code of the external-mode model
   int xc     = 0;   // tick count of the external-mode model
   int ns_run = 0;
   int ew_run = 0;
   logic [5:0] prev_a = 6'b011110;
   bit done = 0;

   function automatic logic [5:0] lamps_of(int ph);
      case (ph)
         0:       return 6'b011_110;
         1:       return 6'b011_101;
         2:       return 6'b110_011;
         default: return 6'b101_011;
      endcase
   endfunction

   function automatic int phase_of(int k);
      int m;
      m = k % PER;
      if (m < G_LEN)                return 0;
      if (m < G_LEN + Y_LEN)        return 1;
      if (m < 2 * G_LEN + Y_LEN)    return 2;
      return 3;
   endfunction

   task automatic chk6(string tag, logic [5:0] act, logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s lamps act=%b exp=%b", tag, act, exp);
      end
   endtask

   task automatic chki(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic t, input logic tx, input string tag);
      int zn, ze;
      rst   = r;
      tmr   = t;
      tmr_x = tx;
      @(posedge clk);
      if (r) begin
         n = 0; xp = 0; xc = 0;
      end else begin
         n++;
         if (xp % 2 == 0) begin
            if (tx) begin xp = (xp + 1) % 4; xc = 0; end
         end else if (xc == Y_LEN - 1) begin
            xp = (xp + 1) % 4; xc = 0;
         end else begin
            xc++;
         end
      end
      @(negedge clk);
      chk6(tag, la, lamps_of(phase_of(n)));
      chk6("R8 external mode", lx, lamps_of(xp));
      zn = (la[5] == 1'b0) + (la[4] == 1'b0) + (la[3] == 1'b0);
      ze = (la[2] == 1'b0) + (la[1] == 1'b0) + (la[0] == 1'b0);
      chki("R2 lit lamps per road", zn * 10 + ze, 11);
      chki("R3 red roads", (la[5] == 1'b0) + (la[2] == 1'b0), 1);
      if (r) begin
         ns_run = (la[5] == 1'b0) ? 1 : 0;
         ew_run = (la[2] == 1'b0) ? 1 : 0;
      end else begin
         if (la[5] == 1'b0) ns_run++;
         else if (ns_run > 0) begin chki("R5 ns red run", ns_run, G_LEN + Y_LEN); ns_run = 0; end
         if (la[2] == 1'b0) ew_run++;
         else if (ew_run > 0) begin chki("R5 ew red run", ew_run, G_LEN + Y_LEN); ew_run = 0; end
         if (prev_a[0] == 1'b0 && la[0] == 1'b1) chki("R10 ew green->yellow", int'(la[1]), 0);
         if (prev_a[3] == 1'b0 && la[3] == 1'b1) chki("R10 ns green->yellow", int'(la[4]), 0);
         if (prev_a[1] == 1'b0 && la[1] == 1'b1) chki("R7 ew yellow->ns green", int'(la[3]), 0);
         if (prev_a[4] == 1'b0 && la[4] == 1'b1) chki("R7 ns yellow->ew green", int'(la[0]), 0);
      end
      prev_a = la;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [7:0] lf;
      lf = 8'hA5;
      @(negedge clk);
      // R1: reset state
      cyc(1'b1, 1'b0, 1'b0, "R1 reset state");
      cyc(1'b1, 1'b1, 1'b1, "R1 reset state");
      // R4: four full periods, timer low
      for (int i = 0; i < 4 * PER; i++) cyc(1'b0, 1'b0, 1'b0, "R4 fixed sequence");
      // R6: pseudo-random timer on the internal instance
      for (int i = 0; i < 3 * PER; i++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         cyc(1'b0, lf[0], 1'b0, "R6 timer ignored");
      end
      // R9: reset landing at every position of the period
      for (int ph = 0; ph < PER; ph++) begin
         cyc(1'b1, 1'b0, 1'b0, "R9 reset");
         for (int k = 0; k < ph; k++) cyc(1'b0, 1'b0, 1'b0, "R9 before reset");
         cyc(1'b1, 1'b1, 1'b0, "R9 reset mid-cycle");
         for (int k = 0; k < PER + 1; k++) cyc(1'b0, 1'b0, 1'b0, "R9 after reset");
      end
      // R8: external mode with hold lengths 0..5 on both roads
      cyc(1'b1, 1'b0, 1'b0, "R1 reset state");
      for (int gap = 0; gap < 6; gap++) begin
         for (int road = 0; road < 2; road++) begin
            for (int k = 0; k < gap; k++) cyc(1'b0, 1'b0, 1'b0, "R4 during R8 sweep");
            cyc(1'b0, 1'b0, 1'b1, "R4 during R8 sweep");
            for (int k = 0; k < Y_LEN; k++) cyc(1'b0, 1'b0, 1'b0, "R4 during R8 sweep");
         end
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule